// File: doc/BRIEF.md
# Effective Address Generation Unit

This block forms the 16-bit address that a small 8-bit processor places on its address bus for a data access, an I/O port access or a branch. A decoder presents a mode code, the opcode address held in the program counter, up to two operand bytes and the current values of HL, IX, IY and the accumulator. The block turns these into one address and classifies it as a memory-space or a port-space access.

Inputs are captured on a rising clock edge while `go` is high, and the result appears one cycle later through a single register stage. A two-state machine drives that stage. `S_EMPTY` means no result is held. `S_HELD` means a valid address is presented. The transition `LOAD` (strobe with a supported mode) enters `S_HELD` from either state. The transition `DROP` (no strobe, or an unsupported mode) enters `S_EMPTY` from either state. All 16-bit sums wrap modulo 65536 and raise no error indication.

Top module: `eagu_top`

## Requirements
- R1: While reset is asserted and after reset until the first strobe, `ea_valid`=0, `ea_addr`=0000h and `ea_port`=0.
- R2: With mode 0 (register indirect), the address equals `hl_val`.
- R3: With mode 1 (direct), the address is {`opnd_b1`, `opnd_b0`}: the first operand byte is the low half.
- R4: With mode 2 (PC-relative), the address is `pc_val` + 2 + sign-extended `opnd_b0` (two's complement, bit 7 is the sign), modulo 65536.
- R5: With mode 3 (indexed), the address is the index register + sign-extended `opnd_b0`, modulo 65536. The register is IX when `use_iy`=0 and IY when `use_iy`=1.
- R6: With mode 4 (restart), `opnd_b0` is the restart opcode. Bits 5..3 form t, and the address is 00h:(t×8). All other bits of `opnd_b0` and all of `opnd_b1` have no effect on the address.
- R7: With mode 5 (port), the address is {`acc_val`, `opnd_b0`} and `ea_port`=1. Every other mode gives `ea_port`=0.
- R8: Mode codes 6 and 7 give `ea_valid`=0, `ea_addr`=0000h and `ea_port`=0 one cycle after the strobe.
- R9: Inputs are sampled only on an edge where `go`=1, and the results appear after that edge. After an edge with `go`=0, `ea_valid`=0, `ea_addr`=0000h and `ea_port`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Sample strobe |
| mode | input | 3 | Addressing mode code (0..5 supported) |
| pc_val | input | 16 | Address of the current opcode |
| opnd_b0 | input | 8 | First operand byte (offset, displacement, low address, port or restart opcode) |
| opnd_b1 | input | 8 | Second operand byte (high address) |
| hl_val | input | 16 | HL register pair |
| ix_val | input | 16 | IX index register |
| iy_val | input | 16 | IY index register |
| use_iy | input | 1 | Index register select |
| acc_val | input | 8 | Accumulator |
| ea_addr | output | 16 | Registered effective address |
| ea_valid | output | 1 | Registered address is valid |
| ea_port | output | 1 | Registered address is in I/O space |

## Verification
The assertions assume that `go` and `mode` hold known values at every sampling edge. They also assume that the previous cycle's strobe and mode are what the output stage reports. The immediate checks in the address former assume that the mode code stays steady while its outputs settle. The bench changes inputs only on falling edges and releases reset before the first strobe, so every sampled input is already settled. It covers every mode code, both index registers, the extreme offsets and wrap-around sums.

// File: rtl/eagu_pkg.sv
package eagu_pkg;
    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        AM_REGIND = 3'd0,
        AM_DIRECT = 3'd1,
        AM_RELATV = 3'd2,
        AM_INDEXD = 3'd3,
        AM_RESTRT = 3'd4,
        AM_PORT   = 3'd5
    } amode_t;

    typedef enum logic {
        S_EMPTY = 1'b0,
        S_HELD  = 1'b1
    } stage_t;
endpackage

// File: rtl/eagu_sext.sv
module eagu_sext #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    localparam int EXT_W = OUT_W - IN_W;

    generate
        if (EXT_W > 0) begin : g_ext
            assign dout = {{EXT_W{din[IN_W-1]}}, din};
        end else begin : g_pass
            assign dout = din[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/eagu_core.sv
module eagu_core
    import eagu_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BYTE_W
) (
    input  logic [2:0]    mode,
    input  logic [AW-1:0] pc_val,
    input  logic [BW-1:0] opnd_b0,
    input  logic [BW-1:0] opnd_b1,
    input  logic [AW-1:0] hl_val,
    input  logic [AW-1:0] ix_val,
    input  logic [AW-1:0] iy_val,
    input  logic          use_iy,
    input  logic [BW-1:0] acc_val,
    output logic [AW-1:0] ea,
    output logic          ok,
    output logic          is_io
);
    localparam int RST_LSB = 3;
    localparam int RST_W   = 3;
    localparam int HI_PAD  = AW - RST_LSB - RST_W;
    localparam logic [AW-1:0] REL_BIAS = AW'(2);

    logic [AW-1:0] disp_ext;
    logic [AW-1:0] idx_base;
    logic [AW-1:0] rel_sum;
    logic [AW-1:0] idx_sum;
    logic [AW-1:0] rst_vec;

    eagu_sext #(.IN_W(BW), .OUT_W(AW)) u_sext (
        .din  (opnd_b0),
        .dout (disp_ext)
    );

    assign idx_base = use_iy ? iy_val : ix_val;
    assign rel_sum  = pc_val + REL_BIAS + disp_ext;
    assign idx_sum  = idx_base + disp_ext;
    assign rst_vec  = {{HI_PAD{1'b0}}, opnd_b0[RST_LSB+RST_W-1:RST_LSB], {RST_LSB{1'b0}}};

    always_comb begin
        ea    = '0;
        ok    = 1'b1;
        is_io = 1'b0;
        unique case (mode)
            AM_REGIND: ea = hl_val;
            AM_DIRECT: ea = {opnd_b1, opnd_b0};
            AM_RELATV: ea = rel_sum;
            AM_INDEXD: ea = idx_sum;
            AM_RESTRT: ea = rst_vec;
            AM_PORT: begin
                ea    = {acc_val, opnd_b0};
                is_io = 1'b1;
            end
            default: ok = 1'b0;
        endcase
    end

    // R6
    always_comb begin
        if (mode == AM_RESTRT) begin
            rst_vec_align_chk: assert (ea[RST_LSB-1:0] == '0 && ea[AW-1:RST_LSB+RST_W] == '0);
        end
    end

    // R7
    always_comb begin
        if (mode == AM_PORT) begin
            port_low_chk: assert (ea[BW-1:0] == opnd_b0 && is_io);
        end
    end
endmodule

// File: rtl/eagu_stage.sv
module eagu_stage
    import eagu_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [2:0]    mode,
    input  logic [AW-1:0] ea,
    input  logic          ok,
    input  logic          is_io,
    output logic [AW-1:0] ea_addr,
    output logic          ea_valid,
    output logic          ea_port
);
    stage_t state, state_nx;

    always_comb begin
        unique case (state)
            S_EMPTY: state_nx = (go && ok) ? S_HELD : S_EMPTY;
            S_HELD:  state_nx = (go && ok) ? S_HELD : S_EMPTY;
            default: state_nx = S_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_addr <= '0;
            ea_port <= 1'b0;
        end else if (go && ok) begin
            ea_addr <= ea;
            ea_port <= is_io;
        end else begin
            ea_addr <= '0;
            ea_port <= 1'b0;
        end
    end

    assign ea_valid = (state == S_HELD);

    // R9
    valid_needs_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ea_valid |-> $past(go));

    // R8
    invalid_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) > 3'd5) |-> (!ea_valid && ea_addr == '0));

    // R7
    port_flag_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ea_port |-> (ea_valid && $past(mode) == AM_PORT));

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ea_valid |-> (ea_addr == '0 && !ea_port));
endmodule

// File: rtl/eagu_top.sv
module eagu_top
    import eagu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic [2:0]  mode,
    input  logic [15:0] pc_val,
    input  logic [7:0]  opnd_b0,
    input  logic [7:0]  opnd_b1,
    input  logic [15:0] hl_val,
    input  logic [15:0] ix_val,
    input  logic [15:0] iy_val,
    input  logic        use_iy,
    input  logic [7:0]  acc_val,
    output logic [15:0] ea_addr,
    output logic        ea_valid,
    output logic        ea_port
);
    logic [ADDR_W-1:0] ea_c;
    logic              ok_c;
    logic              io_c;

    eagu_core #(.AW(ADDR_W), .BW(BYTE_W)) u_core (
        .mode    (mode),
        .pc_val  (pc_val),
        .opnd_b0 (opnd_b0),
        .opnd_b1 (opnd_b1),
        .hl_val  (hl_val),
        .ix_val  (ix_val),
        .iy_val  (iy_val),
        .use_iy  (use_iy),
        .acc_val (acc_val),
        .ea      (ea_c),
        .ok      (ok_c),
        .is_io   (io_c)
    );

    eagu_stage #(.AW(ADDR_W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .mode     (mode),
        .ea       (ea_c),
        .ok       (ok_c),
        .is_io    (io_c),
        .ea_addr  (ea_addr),
        .ea_valid (ea_valid),
        .ea_port  (ea_port)
    );
endmodule

// File: tb/sim_eagu_top.sv
module sim_eagu_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic [2:0]  mode = '0;
    logic [15:0] pc_val = '0, hl_val = '0, ix_val = '0, iy_val = '0;
    logic [7:0]  opnd_b0 = '0, opnd_b1 = '0, acc_val = '0;
    logic        use_iy = 1'b0;
    logic [15:0] ea_addr;
    logic        ea_valid, ea_port;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eagu_top u0 (
        .clk(clk), .rst_n(rst_n), .go(go), .mode(mode), .pc_val(pc_val),
        .opnd_b0(opnd_b0), .opnd_b1(opnd_b1), .hl_val(hl_val),
        .ix_val(ix_val), .iy_val(iy_val), .use_iy(use_iy), .acc_val(acc_val),
        .ea_addr(ea_addr), .ea_valid(ea_valid), .ea_port(ea_port)
    );

    task automatic check(input string tag, input logic [15:0] ea_exp,
                         input logic v_exp, input logic p_exp);
        checks++;
        if (ea_addr !== ea_exp || ea_valid !== v_exp || ea_port !== p_exp) begin
            errors++;
            $display("FAIL %s: addr=%h valid=%b port=%b expected addr=%h valid=%b port=%b",
                     tag, ea_addr, ea_valid, ea_port, ea_exp, v_exp, p_exp);
        end
    endtask

    task automatic issue(input logic [2:0] m);
        @(negedge clk);
        mode = m;
        go   = 1'b1;
        @(negedge clk);
        go   = 1'b0;
    endtask

    function automatic logic [15:0] sx(input logic [7:0] b);
        return {{8{b[7]}}, b};
    endfunction

    task automatic t_reset;
        check("R1 in reset", 16'h0000, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 16'h0000, 1'b0, 1'b0);
    endtask

    task automatic t_regind;
        hl_val = 16'hBEEF;
        issue(3'd0);
        check("R2 hl", 16'hBEEF, 1'b1, 1'b0);
    endtask

    task automatic t_direct;
        opnd_b0 = 8'h34; opnd_b1 = 8'h12;
        issue(3'd1);
        check("R3 direct", 16'h1234, 1'b1, 1'b0);
    endtask

    task automatic t_relative;
        pc_val = 16'h0100; opnd_b0 = 8'h7F;
        issue(3'd2);
        check("R4 rel +127", 16'h0100 + 16'd2 + 16'd127, 1'b1, 1'b0);
        opnd_b0 = 8'h80;
        issue(3'd2);
        check("R4 rel -128", 16'h0100 + 16'd2 - 16'd128, 1'b1, 1'b0);
        pc_val = 16'hFFFE; opnd_b0 = 8'h05;
        issue(3'd2);
        check("R4 rel wrap", 16'h0005, 1'b1, 1'b0);
    endtask

    task automatic t_indexed;
        ix_val = 16'h4000; iy_val = 16'h8000; opnd_b0 = 8'hF0;
        use_iy = 1'b0;
        issue(3'd3);
        check("R5 ix neg", 16'h4000 + sx(8'hF0), 1'b1, 1'b0);
        use_iy = 1'b1; opnd_b0 = 8'h10;
        issue(3'd3);
        check("R5 iy pos", 16'h8010, 1'b1, 1'b0);
        iy_val = 16'hFFF8;
        issue(3'd3);
        check("R5 iy wrap", 16'h0008, 1'b1, 1'b0);
        use_iy = 1'b0;
    endtask

    task automatic t_restart;
        for (int t = 0; t < 8; t++) begin
            opnd_b0 = {2'b11, t[2:0], 3'b111};
            opnd_b1 = 8'hA5;
            issue(3'd4);
            check("R6 restart", 16'(t * 8), 1'b1, 1'b0);
        end
        opnd_b0 = 8'b0001_0000; opnd_b1 = 8'hFF;
        issue(3'd4);
        check("R6 other bits ignored", 16'h0010, 1'b1, 1'b0);
    endtask

    task automatic t_port;
        acc_val = 8'h9C; opnd_b0 = 8'h10;
        issue(3'd5);
        check("R7 port", 16'h9C10, 1'b1, 1'b1);
    endtask

    task automatic t_invalid;
        issue(3'd6);
        check("R8 mode 6", 16'h0000, 1'b0, 1'b0);
        issue(3'd7);
        check("R8 mode 7", 16'h0000, 1'b0, 1'b0);
    endtask

    task automatic t_strobe;
        hl_val = 16'h5A5A;
        @(negedge clk);
        mode = 3'd0;
        go   = 1'b1;
        @(posedge clk);
        #1;
        check("R9 after sampling edge", 16'h5A5A, 1'b1, 1'b0);
        @(negedge clk);
        go = 1'b0;
        hl_val = 16'h1111;
        @(negedge clk);
        check("R9 no strobe", 16'h0000, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_regind();
        t_direct();
        t_relative();
        t_indexed();
        t_restart();
        t_port();
        t_invalid();
        t_strobe();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule